// File: doc/BRIEF.md
# Memory Protection Table Pointer CSR Unit

This unit holds the machine-level register that points a later table walker at the root of a memory protection table, and the companion domain configuration word. It sits on the core's CSR access path. Each cycle it decodes the CSR address and the read and write strobes. It returns read data in the same cycle and commits writes at the next rising clock edge.

The pointer register carries three fields: a mode code, a 6-bit supervisor domain identifier and a root page number. Their positions depend on the register width, which is fixed by the `XLEN` parameter (32 or 64). Writes to the pointer are legalized. Writing the bare code, or writing while the protection-table strap is low, clears the whole register. A nonzero code the configured width does not support keeps the old mode, but the identifier and page fields are still updated. While the domain-identifier strap is low, any access to either register is flagged illegal and has no effect.

The CSR path is a control interface with no back-pressure. Every strobe is acted on in the cycle it is presented, so there is no valid/ready pair. The decoded mode, identifier and page number are presented continuously for downstream use.

Top module: `mpt_csr_unit`

## Requirements
- R1: A synchronous reset (`rst_n` low at a rising edge) clears both registers, so every decoded output and every read returns zero.
- R2: The pointer register answers only at CSR address 0xBC0 and the configuration register only at 0xBD1. Accesses to any other address read zero, raise no illegal flag and change no state.
- R3: Read layout for XLEN=64: mode in bits 63:60, identifier in 59:54, page number in 51:0, and bits 53:52 read zero. For XLEN=32: mode in 31:30, identifier in 29:24, page number in 21:0, and bits 23:22 read zero.
- R4: A pointer write whose mode field is 0 (bare) sets mode, identifier and page number all to zero, whatever the other written bits hold.
- R5: While `ext_mpt_en` is low, every pointer write clears all three fields.
- R6: Legal nonzero mode codes are 1 for XLEN=32, and 1, 2 and 3 for XLEN=64. A write with a legal code stores the code, the identifier and the page number, so the stored mode is always 0 or a legal code.
- R7: A pointer write with a nonzero unsupported code keeps the stored mode and still updates the identifier and page number. Unsupported codes are 2 and 3 for XLEN=32 and 4 to 15 for XLEN=64.
- R8: While `ext_sdid_en` is low, a read or write at either register address raises `csr_illegal` in the same cycle, reads zero and changes no state.
- R9: The configuration register stores all XLEN written bits unaltered and reads them back.
- R10: Read data is combinational in the cycle of the access and shows the value before any write in that cycle. A write becomes visible on the outputs only after the next rising edge, and state changes only through a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 12 | CSR address of the access |
| csr_we | input | 1 | Write strobe |
| csr_re | input | 1 | Read strobe |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, valid in the cycle of the read |
| csr_illegal | output | 1 | Access to either register while the identifier strap is low |
| ext_mpt_en | input | 1 | Strap enabling the protection table |
| ext_sdid_en | input | 1 | Strap enabling the domain-identifier registers |
| mpt_mode_o | output | 2 or 4 | Stored mode code (2 bits for XLEN=32, 4 for 64) |
| mpt_sdid_o | output | 6 | Stored supervisor domain identifier |
| mpt_ppn_o | output | 22 or 52 | Stored root page number |

## Verification
The hardest state to reach is the mixed state left by an unsupported mode write. Producing it takes a write carrying a nonzero but unsupported code right after a legal or bare write. The stimulus therefore steps the pointer from legal mode 2 to unsupported code 9, and from bare to code 4. This exposes a stored mode of 0 with a nonzero identifier and page number, which no single write can produce. A second hard case is a write that arrives while the identifier strap is low. That case is checked by dropping the strap, issuing writes that would otherwise clear the register, then raising the strap and reading back the old values.

// File: rtl/mpt_csr_pkg.sv
package mpt_csr_pkg;

  localparam int unsigned CSR_AW = 12;
  localparam int unsigned SDID_W = 6;

  localparam logic [CSR_AW-1:0] PTR_CSR_ADDR = 12'hBC0;
  localparam logic [CSR_AW-1:0] CFG_CSR_ADDR = 12'hBD1;

  // Width of the mode field for a given register width
  function automatic int unsigned mode_width(int unsigned xlen);
    return (xlen == 32) ? 2 : 4;
  endfunction

  // Width of the root page number field
  function automatic int unsigned ppn_width(int unsigned xlen);
    return (xlen == 32) ? 22 : 52;
  endfunction

  // Reserved bits between the identifier and the page number
  function automatic int unsigned gap_width(int unsigned xlen);
    return xlen - mode_width(xlen) - SDID_W - ppn_width(xlen);
  endfunction

  // Nonzero codes the configured width supports
  function automatic logic mode_code_legal(int unsigned xlen, logic [3:0] code);
    if (xlen == 32) return code == 4'd1;
    return (code >= 4'd1) && (code <= 4'd3);
  endfunction

  // Decoded access for one cycle
  typedef struct packed {
    logic ptr_rd;
    logic ptr_wr;
    logic cfg_rd;
    logic cfg_wr;
    logic illegal;
  } mpt_csr_sel_t;

endpackage

// File: rtl/mpt_csr_decode.sv
module mpt_csr_decode
  import mpt_csr_pkg::*;
#(
  parameter logic [CSR_AW-1:0] PTR_ADDR = PTR_CSR_ADDR,
  parameter logic [CSR_AW-1:0] CFG_ADDR = CFG_CSR_ADDR
) (
  input  logic [CSR_AW-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              sdid_en_i,
  output mpt_csr_sel_t      sel_o
);

  logic hit_ptr;
  logic hit_cfg;
  logic touch;

  assign hit_ptr = (addr_i == PTR_ADDR);
  assign hit_cfg = (addr_i == CFG_ADDR);
  assign touch   = we_i | re_i;

  always_comb begin
    sel_o         = '0;
    sel_o.illegal = (hit_ptr | hit_cfg) & touch & ~sdid_en_i;
    sel_o.ptr_rd  = hit_ptr & re_i & sdid_en_i;
    sel_o.ptr_wr  = hit_ptr & we_i & sdid_en_i;
    sel_o.cfg_rd  = hit_cfg & re_i & sdid_en_i;
    sel_o.cfg_wr  = hit_cfg & we_i & sdid_en_i;
  end

endmodule

// File: rtl/mpt_field_codec.sv
module mpt_field_codec
  import mpt_csr_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned MODE_W = mode_width(XLEN),
  parameter int unsigned PPN_W  = ppn_width(XLEN)
) (
  // unpack side: written word to fields
  input  logic [XLEN-1:0]   word_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [SDID_W-1:0] sdid_o,
  output logic [PPN_W-1:0]  ppn_o,
  // pack side: stored fields to read word
  input  logic [MODE_W-1:0] mode_i,
  input  logic [SDID_W-1:0] sdid_i,
  input  logic [PPN_W-1:0]  ppn_i,
  output logic [XLEN-1:0]   word_o
);

  localparam int unsigned GAP_W    = XLEN - MODE_W - SDID_W - PPN_W;
  localparam int unsigned MODE_LSB = XLEN - MODE_W;
  localparam int unsigned SDID_LSB = MODE_LSB - SDID_W;

  assign mode_o = word_i[MODE_LSB +: MODE_W];
  assign sdid_o = word_i[SDID_LSB +: SDID_W];
  assign ppn_o  = word_i[PPN_W-1:0];

  generate
    if (GAP_W > 0) begin : g_gap
      logic unused_gap;
      assign unused_gap = ^word_i[PPN_W +: GAP_W];
      assign word_o = {mode_i, sdid_i, {GAP_W{1'b0}}, ppn_i};
    end else begin : g_nogap
      assign word_o = {mode_i, sdid_i, ppn_i};
    end
  endgenerate

endmodule

// File: rtl/mpt_mode_legalizer.sv
module mpt_mode_legalizer
  import mpt_csr_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned MODE_W = mode_width(XLEN),
  parameter int unsigned PPN_W  = ppn_width(XLEN)
) (
  input  logic              mpt_en_i,
  input  logic [MODE_W-1:0] cur_mode_i,
  input  logic [MODE_W-1:0] wr_mode_i,
  input  logic [SDID_W-1:0] wr_sdid_i,
  input  logic [PPN_W-1:0]  wr_ppn_i,
  output logic [MODE_W-1:0] nxt_mode_o,
  output logic [SDID_W-1:0] nxt_sdid_o,
  output logic [PPN_W-1:0]  nxt_ppn_o
);

  logic bare_req;
  logic code_ok;

  assign bare_req = ~mpt_en_i | (wr_mode_i == '0);
  assign code_ok  = mode_code_legal(XLEN, 4'(wr_mode_i));

  always_comb begin
    if (bare_req) begin
      nxt_mode_o = '0;
      nxt_sdid_o = '0;
      nxt_ppn_o  = '0;
    end else begin
      // identifier and page always follow a non-bare write
      nxt_sdid_o = wr_sdid_i;
      nxt_ppn_o  = wr_ppn_i;
      nxt_mode_o = code_ok ? wr_mode_i : cur_mode_i;
    end
  end

endmodule

// File: rtl/mpt_csr_unit.sv
module mpt_csr_unit
  import mpt_csr_pkg::*;
#(
  parameter int unsigned       XLEN     = 64,
  parameter logic [CSR_AW-1:0] PTR_ADDR = PTR_CSR_ADDR,
  parameter logic [CSR_AW-1:0] CFG_ADDR = CFG_CSR_ADDR,
  localparam int unsigned      MODE_W   = mode_width(XLEN),
  localparam int unsigned      PPN_W    = ppn_width(XLEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic              csr_we,
  input  logic              csr_re,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_illegal,
  input  logic              ext_mpt_en,
  input  logic              ext_sdid_en,
  output logic [MODE_W-1:0] mpt_mode_o,
  output logic [SDID_W-1:0] mpt_sdid_o,
  output logic [PPN_W-1:0]  mpt_ppn_o
);

  mpt_csr_sel_t sel;

  logic [MODE_W-1:0] mode_q, wr_mode, nxt_mode;
  logic [SDID_W-1:0] sdid_q, wr_sdid, nxt_sdid;
  logic [PPN_W-1:0]  ppn_q,  wr_ppn,  nxt_ppn;
  logic [XLEN-1:0]   cfg_q;
  logic [XLEN-1:0]   ptr_word;

  mpt_csr_decode #(
    .PTR_ADDR (PTR_ADDR),
    .CFG_ADDR (CFG_ADDR)
  ) u_decode (
    .addr_i    (csr_addr),
    .we_i      (csr_we),
    .re_i      (csr_re),
    .sdid_en_i (ext_sdid_en),
    .sel_o     (sel)
  );

  mpt_field_codec #(
    .XLEN   (XLEN),
    .MODE_W (MODE_W),
    .PPN_W  (PPN_W)
  ) u_codec (
    .word_i (csr_wdata),
    .mode_o (wr_mode),
    .sdid_o (wr_sdid),
    .ppn_o  (wr_ppn),
    .mode_i (mode_q),
    .sdid_i (sdid_q),
    .ppn_i  (ppn_q),
    .word_o (ptr_word)
  );

  mpt_mode_legalizer #(
    .XLEN   (XLEN),
    .MODE_W (MODE_W),
    .PPN_W  (PPN_W)
  ) u_legal (
    .mpt_en_i   (ext_mpt_en),
    .cur_mode_i (mode_q),
    .wr_mode_i  (wr_mode),
    .wr_sdid_i  (wr_sdid),
    .wr_ppn_i   (wr_ppn),
    .nxt_mode_o (nxt_mode),
    .nxt_sdid_o (nxt_sdid),
    .nxt_ppn_o  (nxt_ppn)
  );

  // Pointer register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      sdid_q <= '0;
      ppn_q  <= '0;
    end else if (sel.ptr_wr) begin
      mode_q <= nxt_mode;
      sdid_q <= nxt_sdid;
      ppn_q  <= nxt_ppn;
    end
  end

  // Domain configuration register, no legalization
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (sel.cfg_wr) begin
      cfg_q <= csr_wdata;
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (sel.ptr_rd)      csr_rdata = ptr_word;
    else if (sel.cfg_rd) csr_rdata = cfg_q;
  end

  assign csr_illegal = sel.illegal;
  assign mpt_mode_o  = mode_q;
  assign mpt_sdid_o  = sdid_q;
  assign mpt_ppn_o   = ppn_q;

  // ---------------- assertions ----------------
  AST_ILLEGAL_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |=> ($stable(mode_q) && $stable(sdid_q) && $stable(ppn_q) && $stable(cfg_q))); // R8

  AST_ILLEGAL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (csr_rdata == '0)); // R8

  AST_BARE_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.ptr_wr && (csr_wdata[XLEN-1 -: MODE_W] == '0))
      |=> (mpt_mode_o == '0 && mpt_sdid_o == '0 && mpt_ppn_o == '0)); // R4

  AST_STRAP_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.ptr_wr && !ext_mpt_en)
      |=> (mpt_mode_o == '0 && mpt_sdid_o == '0 && mpt_ppn_o == '0)); // R5

  AST_BAD_CODE_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.ptr_wr && ext_mpt_en && (csr_wdata[XLEN-1 -: MODE_W] != '0)
     && !mode_code_legal(XLEN, 4'(csr_wdata[XLEN-1 -: MODE_W])))
      |=> $stable(mpt_mode_o)); // R7

  AST_MODE_ALWAYS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mpt_mode_o == '0) || mode_code_legal(XLEN, 4'(mpt_mode_o))); // R6

  AST_QUIET_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    !sel.ptr_wr |=> ($stable(mpt_mode_o) && $stable(mpt_sdid_o) && $stable(mpt_ppn_o))); // R10

  AST_CFG_STORES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    sel.cfg_wr |=> (csr_rdata == $past(csr_wdata) || !sel.cfg_rd)); // R9

endmodule

// File: tb/mpt_csr_unit_tb.sv
`timescale 1ns/1ps
module mpt_csr_unit_tb;

  localparam int XLEN = 64;
  localparam logic [11:0] A_PTR = 12'hBC0;
  localparam logic [11:0] A_CFG = 12'hBD1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [11:0]      csr_addr;
  logic             csr_we, csr_re;
  logic [XLEN-1:0]  csr_wdata;
  logic [XLEN-1:0]  csr_rdata;
  logic             csr_illegal;
  logic             ext_mpt_en, ext_sdid_en;
  logic [3:0]       mpt_mode_o;
  logic [5:0]       mpt_sdid_o;
  logic [51:0]      mpt_ppn_o;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  always #2.5 clk = ~clk;

  mpt_csr_unit #(.XLEN(XLEN)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_addr    (csr_addr),
    .csr_we      (csr_we),
    .csr_re      (csr_re),
    .csr_wdata   (csr_wdata),
    .csr_rdata   (csr_rdata),
    .csr_illegal (csr_illegal),
    .ext_mpt_en  (ext_mpt_en),
    .ext_sdid_en (ext_sdid_en),
    .mpt_mode_o  (mpt_mode_o),
    .mpt_sdid_o  (mpt_sdid_o),
    .mpt_ppn_o   (mpt_ppn_o)
  );

  function automatic logic [63:0] mk(logic [3:0] m, logic [5:0] s, logic [1:0] g, logic [51:0] p);
    return {m, s, g, p};
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_fields(string req, logic [3:0] m, logic [5:0] s, logic [51:0] p);
    chk(req, "mode", 64'(mpt_mode_o), 64'(m));
    chk(req, "sdid", 64'(mpt_sdid_o), 64'(s));
    chk(req, "ppn",  64'(mpt_ppn_o),  64'(p));
  endtask

  task automatic do_write(logic [11:0] a, logic [63:0] d, output logic ill);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    #1 ill = csr_illegal;
    @(negedge clk);
    csr_we = 1'b0; csr_wdata = '0;
  endtask

  task automatic do_read(logic [11:0] a, output logic [63:0] d, output logic ill);
    @(negedge clk);
    csr_addr = a; csr_re = 1'b1;
    #1 d = csr_rdata; ill = csr_illegal;
    csr_re = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] d; logic ill;
    chk_fields("R1", 4'd0, 6'd0, 52'd0);
    do_read(A_PTR, d, ill);
    chk("R1", "pointer read after reset", d, 64'd0);
    do_read(A_CFG, d, ill);
    chk("R1", "config read after reset", d, 64'd0);
  endtask

  task automatic t_legal_layout();
    logic [63:0] d; logic ill;
    do_write(A_PTR, mk(4'd2, 6'h2A, 2'b11, 52'h0_0123_4567_89AB), ill);
    chk_fields("R6", 4'd2, 6'h2A, 52'h0_0123_4567_89AB);
    do_read(A_PTR, d, ill);
    chk("R3", "packed read, gap bits zero", d, mk(4'd2, 6'h2A, 2'b00, 52'h0_0123_4567_89AB));
    do_write(A_PTR, mk(4'd3, 6'h3F, 2'b01, 52'h1), ill);
    chk_fields("R6", 4'd3, 6'h3F, 52'h1);
    do_read(A_PTR, d, ill);
    chk("R3", "packed read mode 3", d, mk(4'd3, 6'h3F, 2'b00, 52'h1));
    do_write(A_PTR, mk(4'd2, 6'h2A, 2'b00, 52'h0_0123_4567_89AB), ill);
  endtask

  task automatic t_unsupported();
    logic [63:0] d; logic ill;
    do_write(A_PTR, mk(4'd9, 6'h15, 2'b00, 52'hF_EDCB_A987_6543), ill);
    chk_fields("R7", 4'd2, 6'h15, 52'hF_EDCB_A987_6543);
    do_read(A_PTR, d, ill);
    chk("R7", "read after code 9", d, mk(4'd2, 6'h15, 2'b00, 52'hF_EDCB_A987_6543));
  endtask

  task automatic t_bare();
    logic ill;
    do_write(A_PTR, mk(4'd0, 6'h11, 2'b10, 52'hABC), ill);
    chk_fields("R4", 4'd0, 6'd0, 52'd0);
    // unsupported code from bare keeps mode 0 but loads the other fields
    do_write(A_PTR, mk(4'd4, 6'h07, 2'b00, 52'h5), ill);
    chk_fields("R7", 4'd0, 6'h07, 52'h5);
  endtask

  task automatic t_strap_off();
    logic ill;
    do_write(A_PTR, mk(4'd1, 6'h0C, 2'b00, 52'h99), ill);
    chk_fields("R6", 4'd1, 6'h0C, 52'h99);
    ext_mpt_en = 1'b0;
    do_write(A_PTR, mk(4'd1, 6'h03, 2'b00, 52'h9), ill);
    chk_fields("R5", 4'd0, 6'd0, 52'd0);
    ext_mpt_en = 1'b1;
  endtask

  task automatic t_timing();
    logic [63:0] d;
    @(negedge clk);
    csr_addr = A_PTR; csr_wdata = mk(4'd3, 6'h22, 2'b00, 52'h444); csr_we = 1'b1; csr_re = 1'b1;
    #1 d = csr_rdata;
    chk("R10", "read during write shows old", d, 64'd0);
    chk("R10", "output before edge", 64'(mpt_mode_o), 64'd0);
    @(posedge clk); #1;
    chk("R10", "output after edge", 64'(mpt_mode_o), 64'd3);
    chk("R10", "read after edge", csr_rdata, mk(4'd3, 6'h22, 2'b00, 52'h444));
    @(negedge clk);
    csr_we = 1'b0; csr_re = 1'b0;
    repeat (3) @(negedge clk);
    chk_fields("R10", 4'd3, 6'h22, 52'h444);
  endtask

  task automatic t_cfg();
    logic [63:0] d; logic ill;
    do_write(A_CFG, 64'hFFFF_FFFF_FFFF_FFFF, ill);
    do_read(A_CFG, d, ill);
    chk("R9", "config all ones", d, 64'hFFFF_FFFF_FFFF_FFFF);
    do_write(A_CFG, 64'h0123_4567_89AB_CDEF, ill);
    do_read(A_CFG, d, ill);
    chk("R9", "config pattern", d, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_sdid_off();
    logic [63:0] d; logic ill;
    ext_sdid_en = 1'b0;
    do_write(A_PTR, 64'd0, ill);
    chk("R8", "illegal on pointer write", 64'(ill), 64'd1);
    do_write(A_CFG, 64'd0, ill);
    chk("R8", "illegal on config write", 64'(ill), 64'd1);
    do_read(A_PTR, d, ill);
    chk("R8", "illegal on pointer read", 64'(ill), 64'd1);
    chk("R8", "pointer read data zero", d, 64'd0);
    do_read(A_CFG, d, ill);
    chk("R8", "config read data zero", d, 64'd0);
    chk_fields("R8", 4'd3, 6'h22, 52'h444);
    ext_sdid_en = 1'b1;
    do_read(A_CFG, d, ill);
    chk("R8", "config kept", d, 64'h0123_4567_89AB_CDEF);
    chk("R8", "no illegal when enabled", 64'(ill), 64'd0);
  endtask

  task automatic t_decode();
    logic [63:0] d; logic ill;
    do_write(12'hBC1, mk(4'd0, 6'd0, 2'b00, 52'd0), ill);
    chk("R2", "no illegal off-address", 64'(ill), 64'd0);
    chk_fields("R2", 4'd3, 6'h22, 52'h444);
    do_write(12'hBD0, 64'd0, ill);
    do_read(12'hBD0, d, ill);
    chk("R2", "off-address read zero", d, 64'd0);
    do_read(A_CFG, d, ill);
    chk("R2", "config untouched by 0xBD0", d, 64'h0123_4567_89AB_CDEF);
    ext_sdid_en = 1'b0;
    do_read(12'h300, d, ill);
    chk("R2", "no illegal on other CSR with strap low", 64'(ill), 64'd0);
    ext_sdid_en = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; csr_addr = '0; csr_we = 1'b0; csr_re = 1'b0; csr_wdata = '0;
    ext_mpt_en = 1'b1; ext_sdid_en = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_legal_layout();
    t_unsupported();
    t_bare();
    t_strap_off();
    t_timing();
    t_cfg();
    t_sdid_off();
    t_decode();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule